// File: doc/BRIEF.md
# Oversampled Asynchronous Serial Receiver

This block receives asynchronous serial characters on a single line. A one-clock sample enable, pulsed at sixteen times the baud rate, paces all timing. While idle the receiver watches the synchronized line for a low level. The low level counts as a start bit only after it has stayed low for eight consecutive sample ticks; a shorter low pulse is dropped and the receiver keeps waiting. Once a start bit is accepted, the receiver samples eight data bits (least significant first), then an optional parity bit, then one stop bit. Every sample is taken at the nominal centre of its bit. The first data sample falls 24 ticks after the first low sample, and each later sample follows the one before it by 16 ticks.

A finished character is copied into a holding register and a ready flag is raised. Parity-error and framing-error flags travel with that character. A one-cycle read strobe clears the ready flag. A synchronous abort command stops any reception in progress and discards the partial character. Baud-rate generation is outside this block and is the job of whatever drives the sample enable.

Top module: `srx_uart_rx`

## Requirements
- R1: After reset, rx_data is 0x00 and rx_ready, par_err and frm_err are all 0.
- R2: A low level on rx_in that lasts 7 sample ticks or fewer, followed by a high level, starts no reception, and rx_ready stays 0.
- R3: A low level lasting 8 sample ticks is accepted as a start bit, even if the line goes high right after. The receiver then samples the rest of the frame, so an all-high remainder yields 0xFF.
- R4: Counting the first low sample tick as tick 0, data bit k (k = 0..7, bit 0 arrives first and lands in rx_data[0]) is sampled at exactly tick 24 + 16k. The line level at any other tick has no effect on the character.
- R5: With par_en = 1, the bit after data bit 7 is parity. par_odd = 0 selects even parity, where data plus parity hold an even number of ones, and par_odd = 1 selects odd parity. A mismatch sets par_err together with that character. With par_en = 0, par_err is 0 and the stop bit follows data bit 7 directly.
- R6: A stop-bit sample of 0 sets frm_err with that character, and the character is still stored and flagged ready. A stop-bit sample of 1 gives frm_err = 0.
- R7: After the stop-bit sample tick, rx_data holds the received byte and rx_ready is 1.
- R8: A one-cycle pulse on rd_strobe clears rx_ready and leaves rx_data unchanged.
- R9: A pulse on rx_abort during a frame returns the receiver to idle. The partial character never reaches rx_data, rx_ready is not set, and the next full frame is received correctly.
- R10: When rd_strobe is high in the same cycle that a new character is stored, rx_ready stays 1 and rx_data takes the new character.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| smp_tick | input | 1 | One-cycle sample enable at 16x the baud rate |
| rx_in | input | 1 | Serial receive line, idle high, asynchronous |
| par_en | input | 1 | 1 = frame carries a parity bit |
| par_odd | input | 1 | 0 = even parity, 1 = odd parity |
| rx_abort | input | 1 | Synchronous command: drop the reception in progress |
| rd_strobe | input | 1 | One-cycle read of the holding register; clears rx_ready |
| rx_data | output | 8 | Holding register: last received character |
| rx_ready | output | 1 | Holding register contains an unread character |
| par_err | output | 1 | Parity mismatch on the held character |
| frm_err | output | 1 | Stop bit sampled low on the held character |

## Verification
Two actions can fall in the same clock cycle: a read of the holding register and the storing of a newly completed character. To force this, the bench leaves one character unread and then pulses rd_strobe in exactly the clock cycle that carries the stop-bit sample tick of the next frame. The result is correct if rx_ready is still 1 afterwards and rx_data shows the new byte rather than the old one. The sample points themselves are checked with frames that drive the opposite level on every tick except the exact sampling tick.

// File: rtl/srx_pkg.sv
package srx_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } srx_state_e;
endpackage

// File: rtl/srx_sync.sv
module srx_sync #(
  parameter int   STAGES    = 2,
  parameter logic RESET_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_in,
  output logic d_out
);
  logic [STAGES-1:0] pipe_q;
  logic [STAGES-1:0] pipe_n;

  generate
    if (STAGES == 1) begin : g_one
      always_comb pipe_n = d_in;
    end else begin : g_many
      always_comb pipe_n = {pipe_q[STAGES-2:0], d_in};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe_q <= {STAGES{RESET_VAL}};
    else        pipe_q <= pipe_n;
  end

  assign d_out = pipe_q[STAGES-1];
endmodule

// File: rtl/srx_framer.sv
module srx_framer
  import srx_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int OSR       = 16,
  parameter int START_MIN = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              line,
  input  logic              par_en,
  input  logic              par_odd,
  input  logic              abort,
  output logic              done,
  output logic [DATA_W-1:0] data,
  output logic              perr,
  output logic              ferr
);
  localparam int MID        = OSR / 2;
  localparam int FIRST_WAIT = OSR + MID - START_MIN;
  localparam int CW         = $clog2(OSR + MID + 1);
  localparam int LW         = $clog2(START_MIN + 1);
  localparam int BW         = $clog2(DATA_W + 3);
  localparam logic [CW-1:0] WAIT_FIRST = CW'(FIRST_WAIT);
  localparam logic [CW-1:0] WAIT_BIT   = CW'(OSR - 1);
  localparam logic [LW-1:0] LOW_LAST   = LW'(START_MIN - 1);
  localparam logic [BW-1:0] DW_B       = BW'(DATA_W);

  srx_state_e        state_q, state_n;
  logic [LW-1:0]     low_q, low_n;
  logic [CW-1:0]     cnt_q, cnt_n;
  logic [BW-1:0]     bidx_q, bidx_n;
  logic [DATA_W-1:0] sh_q, sh_n;
  logic              acc_q, acc_n;
  logic              pe_q, pe_n;
  logic              perr_q, perr_n;
  logic [BW-1:0]     stop_idx;

  assign stop_idx = DW_B + {{(BW-1){1'b0}}, pe_q};

  // next-state process
  always_comb begin
    state_n = state_q;
    low_n   = low_q;
    cnt_n   = cnt_q;
    bidx_n  = bidx_q;
    sh_n    = sh_q;
    acc_n   = acc_q;
    pe_n    = pe_q;
    perr_n  = perr_q;
    done    = 1'b0;
    ferr    = 1'b0;
    if (abort) begin
      state_n = ST_IDLE;
      low_n   = '0;
      cnt_n   = '0;
      bidx_n  = '0;
    end else if (tick) begin
      unique case (state_q)
        ST_IDLE: begin
          if (line) begin
            low_n = '0;
          end else if (low_q == LOW_LAST) begin
            state_n = ST_RUN;
            low_n   = '0;
            cnt_n   = WAIT_FIRST;
            bidx_n  = '0;
            acc_n   = par_odd;
            pe_n    = par_en;
            perr_n  = 1'b0;
          end else begin
            low_n = low_q + 1'b1;
          end
        end
        ST_RUN: begin
          if (cnt_q != '0) begin
            cnt_n = cnt_q - 1'b1;
          end else if (bidx_q == stop_idx) begin
            done    = 1'b1;
            ferr    = ~line;
            state_n = ST_IDLE;
            bidx_n  = '0;
          end else begin
            cnt_n  = WAIT_BIT;
            bidx_n = bidx_q + 1'b1;
            if (bidx_q < DW_B) begin
              sh_n  = {line, sh_q[DATA_W-1:1]};
              acc_n = acc_q ^ line;
            end else begin
              perr_n = acc_q ^ line;
            end
          end
        end
        default: state_n = ST_IDLE;
      endcase
    end
  end

  // register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      low_q   <= '0;
      cnt_q   <= '0;
      bidx_q  <= '0;
      sh_q    <= '0;
      acc_q   <= 1'b0;
      pe_q    <= 1'b0;
      perr_q  <= 1'b0;
    end else begin
      state_q <= state_n;
      low_q   <= low_n;
      cnt_q   <= cnt_n;
      bidx_q  <= bidx_n;
      sh_q    <= sh_n;
      acc_q   <= acc_n;
      pe_q    <= pe_n;
      perr_q  <= perr_n;
    end
  end

  assign data = sh_q;
  assign perr = perr_q;

  // R9
  abort_to_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> (state_q == ST_IDLE && low_q == '0));

  // R2
  high_keeps_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE && tick && line) |=> (state_q == ST_IDLE && low_q == '0));

  // R4
  run_wait_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RUN) |-> (cnt_q <= WAIT_FIRST && bidx_q <= stop_idx));

  // R7
  done_only_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (tick && !abort && state_q == ST_RUN));
endmodule

// File: rtl/srx_hold.sv
module srx_hold #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] din,
  input  logic              perr_in,
  input  logic              ferr_in,
  input  logic              rd,
  output logic [DATA_W-1:0] dout,
  output logic              ready,
  output logic              perr,
  output logic              ferr
);
  logic [DATA_W-1:0] data_q, data_n;
  logic              rdy_q, rdy_n;
  logic              perr_q, perr_n;
  logic              ferr_q, ferr_n;

  // next-state process: a load outranks a read in the same cycle
  always_comb begin
    data_n = data_q;
    rdy_n  = rdy_q;
    perr_n = perr_q;
    ferr_n = ferr_q;
    if (load) begin
      data_n = din;
      rdy_n  = 1'b1;
      perr_n = perr_in;
      ferr_n = ferr_in;
    end else if (rd) begin
      rdy_n = 1'b0;
    end
  end

  // register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      rdy_q  <= 1'b0;
      perr_q <= 1'b0;
      ferr_q <= 1'b0;
    end else begin
      data_q <= data_n;
      rdy_q  <= rdy_n;
      perr_q <= perr_n;
      ferr_q <= ferr_n;
    end
  end

  assign dout  = data_q;
  assign ready = rdy_q;
  assign perr  = perr_q;
  assign ferr  = ferr_q;

  // R7
  load_sets_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (ready && dout == $past(din)));

  // R8
  read_clears_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && !load) |=> (!ready && $stable(dout)));

  // R10
  load_beats_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && load) |=> ready);
endmodule

// File: rtl/srx_uart_rx.sv
module srx_uart_rx #(
  parameter int DATA_W      = 8,
  parameter int OSR         = 16,
  parameter int START_MIN   = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              smp_tick,
  input  logic              rx_in,
  input  logic              par_en,
  input  logic              par_odd,
  input  logic              rx_abort,
  input  logic              rd_strobe,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_ready,
  output logic              par_err,
  output logic              frm_err
);
  logic [1:0]        rst_pipe_q;
  logic              rst_sync_n;
  logic              line_s;
  logic              chr_done;
  logic [DATA_W-1:0] chr_data;
  logic              chr_perr;
  logic              chr_ferr;

  // reset: asserted asynchronously, released after two clock edges
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe_q[1];

  srx_sync #(
    .STAGES    (SYNC_STAGES),
    .RESET_VAL (1'b1)
  ) i_line_sync (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .d_in  (rx_in),
    .d_out (line_s)
  );

  srx_framer #(
    .DATA_W    (DATA_W),
    .OSR       (OSR),
    .START_MIN (START_MIN)
  ) i_framer (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .tick    (smp_tick),
    .line    (line_s),
    .par_en  (par_en),
    .par_odd (par_odd),
    .abort   (rx_abort),
    .done    (chr_done),
    .data    (chr_data),
    .perr    (chr_perr),
    .ferr    (chr_ferr)
  );

  srx_hold #(
    .DATA_W (DATA_W)
  ) i_hold (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .load    (chr_done),
    .din     (chr_data),
    .perr_in (chr_perr),
    .ferr_in (chr_ferr),
    .rd      (rd_strobe),
    .dout    (rx_data),
    .ready   (rx_ready),
    .perr    (par_err),
    .ferr    (frm_err)
  );
endmodule

// File: tb/test_srx_uart_rx.sv
module test_srx_uart_rx;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       smp_tick = 1'b0;
  logic       rx_in = 1'b1;
  logic       par_en = 1'b0;
  logic       par_odd = 1'b0;
  logic       rx_abort = 1'b0;
  logic       rd_strobe = 1'b0;
  logic [7:0] rx_data;
  logic       rx_ready;
  logic       par_err;
  logic       frm_err;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  srx_uart_rx i_srx_uart_rx (
    .clk       (clk),
    .rst_n     (rst_n),
    .smp_tick  (smp_tick),
    .rx_in     (rx_in),
    .par_en    (par_en),
    .par_odd   (par_odd),
    .rx_abort  (rx_abort),
    .rd_strobe (rd_strobe),
    .rx_data   (rx_data),
    .rx_ready  (rx_ready),
    .par_err   (par_err),
    .frm_err   (frm_err)
  );

  // vector: [12] sharp, [11] bad stop, [10] flip parity, [9] odd, [8] parity on, [7:0] byte
  localparam logic [12:0] VEC [8] = '{
    13'b0_0_0_0_0_10100101,
    13'b1_0_0_0_0_00110110,
    13'b0_0_0_0_1_11001010,
    13'b0_0_0_1_1_01110001,
    13'b0_0_1_0_1_10000001,
    13'b0_0_1_1_1_11111111,
    13'b0_1_0_0_0_01010101,
    13'b1_1_1_1_1_00000000
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick1(input logic v, input logic rd);
    rx_in = v;
    repeat (3) @(negedge clk);
    smp_tick  = 1'b1;
    rd_strobe = rd;
    @(negedge clk);
    smp_tick  = 1'b0;
    rd_strobe = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) tick1(1'b1, 1'b0);
  endtask

  task automatic read_pulse();
    rd_strobe = 1'b1;
    @(negedge clk);
    rd_strobe = 1'b0;
  endtask

  task automatic send_frame(input logic [7:0] d, input logic pe, input logic po,
                            input logic flip, input logic bad, input logic sharp,
                            input logic rdlast);
    logic [9:0] b;
    int nb;
    int last;
    b = '0;
    b[7:0] = d;
    par_en  = pe;
    par_odd = po;
    if (pe) begin
      b[8] = (^d) ^ po ^ flip;
      b[9] = ~bad;
      nb = 10;
    end else begin
      b[8] = ~bad;
      nb = 9;
    end
    last = 24 + 16 * (nb - 1);
    for (int t = 0; t <= last; t++) begin
      int k;
      logic v;
      if (t < 8) v = 1'b0;
      else if (!sharp && t < 16) v = 1'b0;
      else if (!sharp) v = b[(t - 16) / 16];
      else begin
        k = (t <= 24) ? 0 : (t - 9) / 16;
        v = (t == 24 + 16 * k) ? b[k] : ~b[k];
      end
      tick1(v, rdlast && (t == last));
    end
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin : main
    logic [7:0] held;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);

    // R1 reset state
    chk("R1 data", rx_data, 8'h00);
    chk("R1 ready", {7'd0, rx_ready}, 8'd0);
    chk("R1 par_err", {7'd0, par_err}, 8'd0);
    chk("R1 frm_err", {7'd0, frm_err}, 8'd0);

    idle(4);
    // table walk: R4 R5 R6 R7 R8
    for (int i = 0; i < 8; i++) begin
      logic [12:0] v;
      v = VEC[i];
      send_frame(v[7:0], v[8], v[9], v[10], v[11], v[12], 1'b0);
      chk("R4 data", rx_data, v[7:0]);
      chk("R7 ready", {7'd0, rx_ready}, 8'd1);
      chk("R5 par_err", {7'd0, par_err}, {7'd0, v[8] & v[10]});
      chk("R6 frm_err", {7'd0, frm_err}, {7'd0, v[11]});
      read_pulse();
      chk("R8 ready cleared", {7'd0, rx_ready}, 8'd0);
      chk("R8 data kept", rx_data, v[7:0]);
      idle(4);
    end

    // R2: a 7-tick low pulse is ignored
    par_en = 1'b0;
    for (int i = 0; i < 7; i++) tick1(1'b0, 1'b0);
    idle(200);
    chk("R2 short low ignored", {7'd0, rx_ready}, 8'd0);
    chk("R2 data untouched", rx_data, 8'h00);

    // R3: an 8-tick low pulse starts a frame; the rest is high
    for (int i = 0; i < 8; i++) tick1(1'b0, 1'b0);
    idle(200);
    chk("R3 start accepted", {7'd0, rx_ready}, 8'd1);
    chk("R3 data all ones", rx_data, 8'hFF);
    chk("R3 frm_err", {7'd0, frm_err}, 8'd0);
    read_pulse();

    // R9: abort in mid-frame
    held = rx_data;
    for (int i = 0; i < 40; i++) tick1(1'b0, 1'b0);
    rx_abort = 1'b1;
    @(negedge clk);
    rx_abort = 1'b0;
    idle(200);
    chk("R9 no ready after abort", {7'd0, rx_ready}, 8'd0);
    chk("R9 data unchanged", rx_data, held);
    send_frame(8'h3C, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    chk("R9 next frame ready", {7'd0, rx_ready}, 8'd1);
    chk("R9 next frame data", rx_data, 8'h3C);
    idle(4);

    // R10: unread character, then read in the cycle the next one is stored
    send_frame(8'hC3, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
    chk("R10 ready held on collision", {7'd0, rx_ready}, 8'd1);
    chk("R10 new data on collision", rx_data, 8'hC3);
    read_pulse();
    chk("R8 ready cleared after collision", {7'd0, rx_ready}, 8'd0);

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule